// File: doc/BRIEF.md
# Ring-Bus Tagged Associative Memory

This block is one stage of a synchronous token ring. Each cycle a token (valid bit, address, data, info bits) enters from the upstream stage and leaves one cycle later toward the downstream stage. A token the unit claims is lifted off, which leaves an empty slot. The unit injects its own tokens only into slots that arrive empty. Behind the stage sits a small content-addressable store. Each entry holds a variable name together with its value, and the two fields have the same width.

A store operation begins with a command token sent to the unit's store op-code. That token carries an operation tag. Two further tokens addressed to the tag follow, one holding the name and one holding the value, and they may arrive in either order. A lookup begins with a command token sent to the unit's lookup op-code, carrying a tag and a reply address, and is followed by a name token under that tag. The name is compared against every entry in one cycle. On a hit the stored value goes out toward the reply address. On a miss the command token and the name token go back onto the ring unchanged, so that another storage unit further along can try.

Top module: `ring_tag_mem`

## Requirements
- R1: During reset and right after it, `ring_out_valid` and `full_o` are 0.
- R2: A token the unit does not claim appears on the outputs one cycle later with its address, data and info unchanged. An empty slot stays empty unless the unit is injecting.
- R3: When idle, the unit lifts a token whose address equals `WR_OPC` and records data[ADDR_W-1:0] as the tag. It then lifts tokens addressed to the tag with info 2'b01 (name) and info 2'b10 (value), in either order. Every lifted token leaves an empty slot on the output.
- R4: A store whose name is not yet held fills the lowest-numbered free entry. A store whose name is already held replaces that entry's value, and no name is ever held twice.
- R5: When idle, the unit lifts a token whose address equals `RD_OPC`, taking data[ADDR_W-1:0] as the tag and data[2*ADDR_W-1:ADDR_W] as the reply address. It then lifts a token addressed to the tag with info 2'b01 as the name to look up.
- R6: On a lookup hit the unit injects one token: address = reply address, data = stored value, info = 2'b10. The search takes exactly one cycle after the name is lifted.
- R7: On a lookup miss the unit injects the original command token, with the same address, data and info, and then the name token (address = tag, data = name, info = 2'b01), in that order.
- R8: The unit injects only into a slot that arrives empty. A pending injection waits while occupied tokens pass through.
- R9: A store of a new name while all DEPTH entries are used is dropped, and `full_o` rises. `full_o` stays high until reset, and stores that overwrite an existing name still take effect.
- R10: While an operation is in progress, op-code tokens pass through unclaimed. After the operation finishes the unit again claims op-code tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_valid | input | 1 | Upstream slot holds a token |
| ring_in_addr | input | ADDR_W | Upstream token address |
| ring_in_data | input | DATA_W | Upstream token data |
| ring_in_info | input | INFO_W | Upstream token info bits |
| ring_out_valid | output | 1 | Downstream slot holds a token |
| ring_out_addr | output | ADDR_W | Downstream token address |
| ring_out_data | output | DATA_W | Downstream token data |
| ring_out_info | output | INFO_W | Downstream token info bits |
| full_o | output | 1 | Sticky flag: a store was dropped for lack of space |

## Verification
The bench sends store operations in both token orders and then reads them back. It checks that the value comes back to the requested reply address; a unit that keyed the fields by arrival order instead of by info bits would return the name in place of the value. It repeats a store under a known name and expects the new value. A design that allocated a fresh entry each time would fill the array early, raise the full flag too soon, or return stale data. It fills all sixteen entries and then issues one more store of a new name. It expects that store to be dropped with the flag raised, and expects an overwrite and a lookup afterward to still work. Lookup misses must come back as the command token followed by the name token, bit for bit. An op-code token sent in the middle of an operation must pass through untouched; a design that captured it would lose the token from the ring and corrupt the pending store.

// File: rtl/ring_tag_mem_pkg.sv
package ring_tag_mem_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 16;
    parameter int INFO_W = 2;

    localparam logic [INFO_W-1:0] INFO_NAME  = 2'b01;
    localparam logic [INFO_W-1:0] INFO_VALUE = 2'b10;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [INFO_W-1:0] info;
    } token_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR_WAIT, ST_WR_COMMIT, ST_RD_WAIT,
        ST_SEARCH, ST_REPLY, ST_MISS_CMD, ST_MISS_NAME
    } mem_state_e;
endpackage

// File: rtl/tam_ring_stage.sv
module tam_ring_stage
    import ring_tag_mem_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  token_t tok_in,
    input  logic   capture,
    input  logic   inj_valid,
    input  token_t inj_tok,
    output token_t tok_out
);
    token_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (capture)
            out_d = '0;
        else if (tok_in.valid)
            out_d = tok_in;
        else if (inj_valid) begin
            out_d = inj_tok;
            out_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tok_out = out_q;

    // R2
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in.valid && !capture) |=> (out_q == $past(tok_in)));

    // R3
    lift_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !out_q.valid);
endmodule

// File: rtl/tam_cam.sv
module tam_cam #(
    parameter int DEPTH = 16,
    parameter int KEY_W = 16,
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_i,
    input  logic             wr_en_i,
    input  logic [VAL_W-1:0] wr_val_i,
    output logic             hit_o,
    output logic [VAL_W-1:0] rd_val_o,
    output logic             full_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]            used;
        logic [DEPTH-1:0][KEY_W-1:0] keys;
        logic [DEPTH-1:0][VAL_W-1:0] vals;
    } cam_t;

    cam_t             s_d, s_q;
    logic [DEPTH-1:0] hit_vec;
    logic [IDX_W-1:0] hit_idx, free_idx;
    logic             free_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = s_q.used[g] && (s_q.keys[g] == key_i);
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        free_ok  = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!s_q.used[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        s_d = s_q;
        if (wr_en_i) begin
            if (|hit_vec)
                s_d.vals[hit_idx] = wr_val_i;
            else if (free_ok) begin
                s_d.used[free_idx] = 1'b1;
                s_d.keys[free_idx] = key_i;
                s_d.vals[free_idx] = wr_val_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o    = |hit_vec;
    assign rd_val_o = s_q.vals[hit_idx];
    assign full_o   = &s_q.used;

    // R4
    uniq_name_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R4
    alloc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !(|hit_vec) && free_ok) |=>
        ($countones(s_q.used) == $past($countones(s_q.used)) + 1));
endmodule

// File: rtl/ring_tag_mem.sv
module ring_tag_mem
    import ring_tag_mem_pkg::*;
#(
    parameter int                DEPTH  = 16,
    parameter logic [ADDR_W-1:0] WR_OPC = 8'hA0,
    parameter logic [ADDR_W-1:0] RD_OPC = 8'hA1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_in_valid,
    input  logic [ADDR_W-1:0] ring_in_addr,
    input  logic [DATA_W-1:0] ring_in_data,
    input  logic [INFO_W-1:0] ring_in_info,
    output logic              ring_out_valid,
    output logic [ADDR_W-1:0] ring_out_addr,
    output logic [DATA_W-1:0] ring_out_data,
    output logic [INFO_W-1:0] ring_out_info,
    output logic              full_o
);
    typedef struct packed {
        mem_state_e        st;
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] reply;
        logic [DATA_W-1:0] cmd_data;
        logic [INFO_W-1:0] cmd_info;
        logic [DATA_W-1:0] name;
        logic [DATA_W-1:0] value;
        logic              got_name;
        logic              got_val;
        logic              full;
    } ctl_t;

    ctl_t   c_d, c_q;
    token_t tok_in, tok_out, inj_tok;
    logic   capture, inj_valid, cam_wr, cam_hit, cam_full, sending;
    logic [DATA_W-1:0] cam_val;

    assign tok_in = '{valid: ring_in_valid, addr: ring_in_addr,
                      data: ring_in_data, info: ring_in_info};

    always_comb begin
        c_d       = c_q;
        capture   = 1'b0;
        inj_valid = 1'b0;
        inj_tok   = '0;
        cam_wr    = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (tok_in.valid && tok_in.addr == WR_OPC) begin
                    capture    = 1'b1;
                    c_d.tag    = tok_in.data[ADDR_W-1:0];
                    c_d.got_name = 1'b0;
                    c_d.got_val  = 1'b0;
                    c_d.st     = ST_WR_WAIT;
                end else if (tok_in.valid && tok_in.addr == RD_OPC) begin
                    capture      = 1'b1;
                    c_d.tag      = tok_in.data[ADDR_W-1:0];
                    c_d.reply    = tok_in.data[2*ADDR_W-1:ADDR_W];
                    c_d.cmd_data = tok_in.data;
                    c_d.cmd_info = tok_in.info;
                    c_d.st       = ST_RD_WAIT;
                end
            end
            ST_WR_WAIT: begin
                if (tok_in.valid && tok_in.addr == c_q.tag) begin
                    if (tok_in.info == INFO_NAME) begin
                        capture      = 1'b1;
                        c_d.name     = tok_in.data;
                        c_d.got_name = 1'b1;
                    end else if (tok_in.info == INFO_VALUE) begin
                        capture     = 1'b1;
                        c_d.value   = tok_in.data;
                        c_d.got_val = 1'b1;
                    end
                end
                if (c_d.got_name && c_d.got_val) c_d.st = ST_WR_COMMIT;
            end
            ST_WR_COMMIT: begin
                cam_wr = 1'b1;
                if (!cam_hit && cam_full) c_d.full = 1'b1;
                c_d.st = ST_IDLE;
            end
            ST_RD_WAIT: begin
                if (tok_in.valid && tok_in.addr == c_q.tag &&
                    tok_in.info == INFO_NAME) begin
                    capture  = 1'b1;
                    c_d.name = tok_in.data;
                    c_d.st   = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (cam_hit) begin
                    c_d.value = cam_val;
                    c_d.st    = ST_REPLY;
                end else begin
                    c_d.st = ST_MISS_CMD;
                end
            end
            ST_REPLY: begin
                inj_valid = 1'b1;
                inj_tok   = '{valid: 1'b1, addr: c_q.reply,
                              data: c_q.value, info: INFO_VALUE};
                if (!tok_in.valid) c_d.st = ST_IDLE;
            end
            ST_MISS_CMD: begin
                inj_valid = 1'b1;
                inj_tok   = '{valid: 1'b1, addr: RD_OPC,
                              data: c_q.cmd_data, info: c_q.cmd_info};
                if (!tok_in.valid) c_d.st = ST_MISS_NAME;
            end
            ST_MISS_NAME: begin
                inj_valid = 1'b1;
                inj_tok   = '{valid: 1'b1, addr: c_q.tag,
                              data: c_q.name, info: INFO_NAME};
                if (!tok_in.valid) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    tam_ring_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_in   (tok_in),
        .capture  (capture),
        .inj_valid(inj_valid),
        .inj_tok  (inj_tok),
        .tok_out  (tok_out)
    );

    tam_cam #(.DEPTH(DEPTH), .KEY_W(DATA_W), .VAL_W(DATA_W)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_i   (c_q.name),
        .wr_en_i (cam_wr),
        .wr_val_i(c_q.value),
        .hit_o   (cam_hit),
        .rd_val_o(cam_val),
        .full_o  (cam_full)
    );

    assign ring_out_valid = tok_out.valid;
    assign ring_out_addr  = tok_out.addr;
    assign ring_out_data  = tok_out.data;
    assign ring_out_info  = tok_out.info;
    assign full_o         = c_q.full;

    assign sending = (c_q.st == ST_REPLY) || (c_q.st == ST_MISS_CMD) ||
                     (c_q.st == ST_MISS_NAME);

    // R9
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.full |=> c_q.full);

    // R8
    wait_busy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && ring_in_valid) |=> (c_q.st == $past(c_q.st)));

    // R6
    one_cycle_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SEARCH) |=>
        (c_q.st == ST_REPLY || c_q.st == ST_MISS_CMD));

    // R7
    miss_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_MISS_CMD && !ring_in_valid) |=> (c_q.st == ST_MISS_NAME));
endmodule

// File: tb/ring_tag_mem_bench.sv
module ring_tag_mem_bench;
    import ring_tag_mem_pkg::*;

    localparam logic [ADDR_W-1:0] WOP = 8'hA0;
    localparam logic [ADDR_W-1:0] ROP = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr  = '0;
    logic [DATA_W-1:0] in_data  = '0;
    logic [INFO_W-1:0] in_info  = '0;
    logic              out_valid;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic [INFO_W-1:0] out_info;
    logic              full;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [ADDR_W+DATA_W+INFO_W-1:0] exp_q[$];
    string req_q[$];

    always #2.5 clk = ~clk;

    ring_tag_mem u_ring_tag_mem (
        .clk(clk), .rst_n(rst_n),
        .ring_in_valid(in_valid), .ring_in_addr(in_addr),
        .ring_in_data(in_data), .ring_in_info(in_info),
        .ring_out_valid(out_valid), .ring_out_addr(out_addr),
        .ring_out_data(out_data), .ring_out_info(out_info),
        .full_o(full)
    );

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic expect_tok(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                              input logic [INFO_W-1:0] i, input string req);
        exp_q.push_back({a, d, i});
        req_q.push_back(req);
    endtask

    task automatic send(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [INFO_W-1:0] i);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d; in_info = i;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic store(input logic [ADDR_W-1:0] tag, input logic [DATA_W-1:0] nm,
                         input logic [DATA_W-1:0] val, input bit val_first);
        send(WOP, {8'h00, tag}, 2'b00);
        if (val_first) begin
            send(tag, val, INFO_VALUE);
            send(tag, nm, INFO_NAME);
        end else begin
            send(tag, nm, INFO_NAME);
            send(tag, val, INFO_VALUE);
        end
        idle(4);
    endtask

    task automatic lookup(input logic [ADDR_W-1:0] tag, input logic [ADDR_W-1:0] rep,
                          input logic [DATA_W-1:0] nm);
        send(ROP, {rep, tag}, 2'b11);
        send(tag, nm, INFO_NAME);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", $sformatf("unexpected token act=%h/%h/%h exp=none",
                      out_addr, out_data, out_info));
            end else begin
                automatic logic [ADDR_W+DATA_W+INFO_W-1:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                check({out_addr, out_data, out_info} == e, r,
                      $sformatf("act=%h exp=%h", {out_addr, out_data, out_info}, e));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=hung exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(out_valid == 1'b0 && full == 1'b0, "R1",
              $sformatf("in reset act=%b%b exp=00", out_valid, full));
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0 && full == 1'b0, "R1",
              $sformatf("after reset act=%b%b exp=00", out_valid, full));

        // R2: unclaimed tokens pass unchanged
        send(8'h33, 16'hC0DE, 2'b11); expect_tok(8'h33, 16'hC0DE, 2'b11, "R2");
        send(8'h40, 16'h0001, INFO_NAME); expect_tok(8'h40, 16'h0001, INFO_NAME, "R2");
        idle(4);

        // R3 R4: store name first, then read back (R5 R6)
        store(8'h40, 16'h1234, 16'hBEEF, 1'b0);
        lookup(8'h41, 8'h77, 16'h1234);
        expect_tok(8'h77, 16'hBEEF, INFO_VALUE, "R6");
        idle(6);

        // R3: value token first
        store(8'h42, 16'h0055, 16'h0A0A, 1'b1);
        lookup(8'h43, 8'h78, 16'h0055);
        expect_tok(8'h78, 16'h0A0A, INFO_VALUE, "R6");
        idle(6);

        // R4: overwrite existing name
        store(8'h44, 16'h1234, 16'h1111, 1'b0);
        lookup(8'h45, 8'h79, 16'h1234);
        expect_tok(8'h79, 16'h1111, INFO_VALUE, "R4");
        idle(6);

        // R7: miss re-injection, command then name
        lookup(8'h46, 8'h70, 16'h9999);
        expect_tok(ROP, {8'h70, 8'h46}, 2'b11, "R7");
        expect_tok(8'h46, 16'h9999, INFO_NAME, "R7");
        idle(6);

        // R8: pending reply waits behind occupied slots
        lookup(8'h47, 8'h7A, 16'h0055);
        send(8'h10, 16'hAAAA, 2'b00); expect_tok(8'h10, 16'hAAAA, 2'b00, "R8");
        send(8'h11, 16'hBBBB, 2'b00); expect_tok(8'h11, 16'hBBBB, 2'b00, "R8");
        send(8'h12, 16'hCCCC, 2'b00); expect_tok(8'h12, 16'hCCCC, 2'b00, "R8");
        expect_tok(8'h7A, 16'h0A0A, INFO_VALUE, "R8");
        idle(6);

        // R10: op-code token in mid-operation passes through
        send(WOP, 16'h0048, 2'b00);
        send(ROP, 16'h5555, 2'b00); expect_tok(ROP, 16'h5555, 2'b00, "R10");
        send(WOP, 16'h0049, 2'b00); expect_tok(WOP, 16'h0049, 2'b00, "R10");
        send(8'h48, 16'h0777, INFO_NAME);
        send(8'h48, 16'h7777, INFO_VALUE);
        idle(4);
        lookup(8'h4A, 8'h7B, 16'h0777);
        expect_tok(8'h7B, 16'h7777, INFO_VALUE, "R10");
        idle(6);

        // R9: fill remaining entries (3 used so far)
        for (int i = 0; i < 13; i++)
            store(8'h50, 16'h0100 + 16'(i), 16'h2000 + 16'(i), i[0]);
        check(full == 1'b0, "R9", $sformatf("at exactly full act=%b exp=0", full));
        store(8'h51, 16'h0F00, 16'hDEAD, 1'b0);
        check(full == 1'b1, "R9", $sformatf("after dropped store act=%b exp=1", full));
        lookup(8'h52, 8'h71, 16'h0F00);
        expect_tok(ROP, {8'h71, 8'h52}, 2'b11, "R9");
        expect_tok(8'h52, 16'h0F00, INFO_NAME, "R9");
        idle(6);
        lookup(8'h53, 8'h72, 16'h010C);
        expect_tok(8'h72, 16'h200C, INFO_VALUE, "R4");
        idle(6);
        store(8'h54, 16'h1234, 16'h2222, 1'b1);
        lookup(8'h55, 8'h73, 16'h1234);
        expect_tok(8'h73, 16'h2222, INFO_VALUE, "R9");
        idle(6);
        check(full == 1'b1, "R9", $sformatf("sticky act=%b exp=1", full));

        idle(10);
        check(exp_q.size() == 0, "R2",
              $sformatf("missing outputs act=%0d exp=0", exp_q.size()));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule